// File: doc/BRIEF.md
# Power-Down Configuration Sequence Detector

This block models the control logic inside a pseudo-static RAM that decides which power-down mode the part enters. There is no register port for this. The host selects the mode with six ordinary accesses to the highest word address, and each access is separated from the next by a standby period. The first access is a read, and its returned word becomes the reference. The next two accesses are writes that return that reference word. The fourth and fifth accesses are writes that carry the configuration word twice. A final read of the top address commits the new mode. An access that does not fit the pattern cancels the attempt. If that access is itself a read of the top address, it starts a fresh attempt.

Each completed access reaches the detector as a one-cycle strobe that carries its direction, address and data word. For a read, the data word is the value returned by the array. The active-high chip enable `ce2` gates everything. While `ce2` is low, the part sits in power-down: accesses are ignored and the current mode is frozen. The block also reports how many words keep their refresh during that time. Out of reset the mode is deep power-down, which retains nothing.

Top module: `pdcfg_seq_detect`

## Requirements
- R1: After reset, `cfg_mode` is 0 (deep power-down), `seq_done`, `seq_abort` and `pd_active` are 0, and `retain_words` is 0.
- R2: Six accesses complete the sequence: a read of address `TOP_ADDR`, two writes to `TOP_ADDR` of the word just read, two writes to `TOP_ADDR` of the same configuration word, and a read of `TOP_ADDR`. In the cycle after the sixth strobe, `seq_done` is 1 and `cfg_mode` equals bits [1:0] of the configuration word. The mode codes are 0 deep, 1 keep 4 Mbit, 2 keep 8 Mbit and 3 keep 16 Mbit.
- R3: When accesses 2 or 3 are not a write to `TOP_ADDR` carrying the reference word, the attempt is cancelled. This covers access 3 going to another address. `seq_abort` is 1 in the cycle after that strobe, and `cfg_mode` is unchanged.
- R4: When the data word of access 5 differs from that of access 4, or access 6 is not a read of `TOP_ADDR`, the attempt is cancelled and `seq_abort` pulses.
- R5: When a read of `TOP_ADDR` cancels an attempt, that read becomes access 1 of a new attempt. Five further correct accesses then complete it.
- R6: While no attempt is under way, an access other than a read of `TOP_ADDR` raises neither `seq_abort` nor `seq_done`.
- R7: A strobe presented while `ce2` is 0 is ignored. Any attempt under way is dropped when `ce2` goes low, and this drop raises no `seq_abort`.
- R8: In the cycle after `ce2` is first seen low, `pd_active` is 1 and `pd_mode` holds the `cfg_mode` value from before that edge. `retain_words` is then 0, 2^(ADDR_W-3), 2^(ADDR_W-2) or 2^(ADDR_W-1) for modes 0 to 3. `retain_words` is 0 whenever `pd_active` is 0.
- R9: `seq_done` and `seq_abort` are single-cycle pulses and are never 1 together.
- R10: `cfg_mode` changes only in a cycle where `seq_done` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ce2 | input | 1 | Active-high chip enable; low selects power-down |
| op_valid | input | 1 | One-cycle strobe for a completed access |
| op_write | input | 1 | 1 for a write, 0 for a read |
| op_addr | input | ADDR_W | Word address of the access |
| op_data | input | DATA_W | Written word, or the word returned by a read |
| cfg_mode | output | 2 | Committed power-down mode |
| seq_done | output | 1 | Pulse when a sequence completes |
| seq_abort | output | 1 | Pulse when an attempt is cancelled |
| pd_active | output | 1 | The part is in power-down |
| pd_mode | output | 2 | Mode applied at power-down entry |
| retain_words | output | ADDR_W+1 | Number of words still refreshed during power-down |

## Verification
Two events can land on the same clock edge: power-down entry and the final read that commits a new mode. The bench provokes this by lowering `ce2` in the same cycle that it presents the sixth strobe. The expected result is that no `seq_done` appears, that `cfg_mode` keeps its old value, and that `pd_mode` and `retain_words` reflect the earlier mode. A second collision is a cancelling access that also restarts the sequence. For that case the bench expects a `seq_abort` pulse and a later successful completion that counts only five more accesses.

// File: rtl/pdcfg_pkg.sv
package pdcfg_pkg;

   localparam int MODE_W = 2;

   typedef enum logic [MODE_W-1:0] {
      PD_DEEP     = 2'd0,
      PD_KEEP_Q1  = 2'd1,
      PD_KEEP_Q2  = 2'd2,
      PD_KEEP_Q3  = 2'd3
   } pd_mode_e;

   // step reached: number of accesses of the sequence accepted so far
   typedef enum logic [2:0] {
      S_WAIT1 = 3'd0,
      S_HAVE1 = 3'd1,
      S_HAVE2 = 3'd2,
      S_HAVE3 = 3'd3,
      S_HAVE4 = 3'd4,
      S_HAVE5 = 3'd5
   } seq_step_e;

endpackage

// File: rtl/pdcfg_op_decode.sv
module pdcfg_op_decode #(
   parameter int              ADDR_W         = 21,
   parameter int              DATA_W         = 16,
   parameter logic [ADDR_W-1:0] TOP_ADDR     = '1,
   parameter bit              CFG_FULL_MATCH = 1'b1
) (
   input  logic              ce2,
   input  logic              op_valid,
   input  logic              op_write,
   input  logic [ADDR_W-1:0] op_addr,
   input  logic [DATA_W-1:0] op_data,
   input  logic [DATA_W-1:0] ref_word,
   input  logic [DATA_W-1:0] cfg_word,
   output logic              act,
   output logic              top_rd,
   output logic              top_wr,
   output logic              ref_hit,
   output logic              cfg_hit
);
   import pdcfg_pkg::*;

   logic at_top;

   assign act     = op_valid & ce2;
   assign at_top  = (op_addr == TOP_ADDR);
   assign top_rd  = act & at_top & ~op_write;
   assign top_wr  = act & at_top &  op_write;
   assign ref_hit = (op_data == ref_word);

   generate
      if (CFG_FULL_MATCH) begin : g_cfg_full
         assign cfg_hit = (op_data == cfg_word);
      end else begin : g_cfg_mode_only
         assign cfg_hit = (op_data[MODE_W-1:0] == cfg_word[MODE_W-1:0]);
      end
   endgenerate

endmodule

// File: rtl/pdcfg_seq_fsm.sv
module pdcfg_seq_fsm #(
   parameter int DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ce2,
   input  logic              act,
   input  logic              top_rd,
   input  logic              top_wr,
   input  logic              ref_hit,
   input  logic              cfg_hit,
   input  logic [DATA_W-1:0] op_data,
   output logic [DATA_W-1:0] ref_word,
   output logic [DATA_W-1:0] cfg_word,
   output logic              commit,
   output logic              seq_done,
   output logic              seq_abort
);
   import pdcfg_pkg::*;

   seq_step_e step_q, step_d;
   logic      brk, cap_ref, cap_cfg, abort_d;

   always_comb begin
      step_d  = step_q;
      brk     = 1'b0;
      cap_ref = 1'b0;
      cap_cfg = 1'b0;
      commit  = 1'b0;
      abort_d = 1'b0;
      if (act) begin
         unique case (step_q)
            S_WAIT1: if (top_rd) begin
                        step_d  = S_HAVE1;
                        cap_ref = 1'b1;
                     end
            S_HAVE1: if (top_wr && ref_hit) step_d = S_HAVE2; else brk = 1'b1;
            S_HAVE2: if (top_wr && ref_hit) step_d = S_HAVE3; else brk = 1'b1;
            S_HAVE3: if (top_wr) begin
                        step_d  = S_HAVE4;
                        cap_cfg = 1'b1;
                     end else brk = 1'b1;
            S_HAVE4: if (top_wr && cfg_hit) step_d = S_HAVE5; else brk = 1'b1;
            S_HAVE5: if (top_rd) begin
                        step_d = S_WAIT1;
                        commit = 1'b1;
                     end else brk = 1'b1;
            default: step_d = S_WAIT1;
         endcase
         if (brk) begin
            abort_d = 1'b1;
            if (top_rd) begin
               step_d  = S_HAVE1;
               cap_ref = 1'b1;
            end else begin
               step_d  = S_WAIT1;
            end
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         step_q    <= S_WAIT1;
         ref_word  <= '0;
         cfg_word  <= '0;
         seq_done  <= 1'b0;
         seq_abort <= 1'b0;
      end else begin
         step_q    <= ce2 ? step_d : S_WAIT1;
         seq_done  <= commit;
         seq_abort <= abort_d;
         if (cap_ref) ref_word <= op_data;
         if (cap_cfg) cfg_word <= op_data;
      end
   end

endmodule

// File: rtl/pdcfg_pd_ctrl.sv
module pdcfg_pd_ctrl #(
   parameter int ADDR_W = 21
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ce2,
   input  logic              commit,
   input  logic [1:0]        new_mode,
   output logic [1:0]        cfg_mode,
   output logic              pd_active,
   output logic [1:0]        pd_mode,
   output logic [ADDR_W:0]   retain_words
);
   import pdcfg_pkg::*;

   localparam int N_MODES = 1 << MODE_W;

   logic [ADDR_W:0] keep_tbl [N_MODES];

   // mode 0 keeps nothing; each higher code doubles the retained region
   generate
      for (genvar m = 0; m < N_MODES; m++) begin : g_keep
         if (m == 0) begin : g_none
            assign keep_tbl[m] = '0;
         end else begin : g_part
            assign keep_tbl[m] = (ADDR_W+1)'(1) << (ADDR_W - N_MODES + m);
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_mode  <= PD_DEEP;
         pd_mode   <= PD_DEEP;
         pd_active <= 1'b0;
      end else begin
         if (commit) cfg_mode <= new_mode;
         if (!ce2 && !pd_active) pd_mode <= cfg_mode;
         pd_active <= ~ce2;
      end
   end

   assign retain_words = pd_active ? keep_tbl[pd_mode] : '0;

endmodule

// File: rtl/pdcfg_seq_detect.sv
module pdcfg_seq_detect #(
   parameter int                ADDR_W         = 21,
   parameter int                DATA_W         = 16,
   parameter logic [ADDR_W-1:0] TOP_ADDR       = '1,
   parameter bit                CFG_FULL_MATCH = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ce2,
   input  logic              op_valid,
   input  logic              op_write,
   input  logic [ADDR_W-1:0] op_addr,
   input  logic [DATA_W-1:0] op_data,
   output logic [1:0]        cfg_mode,
   output logic              seq_done,
   output logic              seq_abort,
   output logic              pd_active,
   output logic [1:0]        pd_mode,
   output logic [ADDR_W:0]   retain_words
);
   import pdcfg_pkg::*;

   generate
      if (ADDR_W < 4) begin : g_bad_addr
         $error("pdcfg_seq_detect: ADDR_W must be at least 4");
      end
      if (DATA_W < MODE_W) begin : g_bad_data
         $error("pdcfg_seq_detect: DATA_W must hold the mode field");
      end
   endgenerate

   logic              act, top_rd, top_wr, ref_hit, cfg_hit, commit;
   logic [DATA_W-1:0] ref_word, cfg_word;

   pdcfg_op_decode #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W),
      .TOP_ADDR(TOP_ADDR), .CFG_FULL_MATCH(CFG_FULL_MATCH)
   ) i_dec (
      .ce2(ce2), .op_valid(op_valid), .op_write(op_write),
      .op_addr(op_addr), .op_data(op_data),
      .ref_word(ref_word), .cfg_word(cfg_word),
      .act(act), .top_rd(top_rd), .top_wr(top_wr),
      .ref_hit(ref_hit), .cfg_hit(cfg_hit)
   );

   pdcfg_seq_fsm #(.DATA_W(DATA_W)) i_fsm (
      .clk(clk), .rst_n(rst_n), .ce2(ce2),
      .act(act), .top_rd(top_rd), .top_wr(top_wr),
      .ref_hit(ref_hit), .cfg_hit(cfg_hit), .op_data(op_data),
      .ref_word(ref_word), .cfg_word(cfg_word),
      .commit(commit), .seq_done(seq_done), .seq_abort(seq_abort)
   );

   pdcfg_pd_ctrl #(.ADDR_W(ADDR_W)) i_pd (
      .clk(clk), .rst_n(rst_n), .ce2(ce2),
      .commit(commit), .new_mode(cfg_word[MODE_W-1:0]),
      .cfg_mode(cfg_mode), .pd_active(pd_active),
      .pd_mode(pd_mode), .retain_words(retain_words)
   );

endmodule

// File: rtl/pdcfg_seq_detect_chk.sv
module pdcfg_seq_detect_chk #(
   parameter int ADDR_W = 21
) (
   input logic            clk,
   input logic            rst_n,
   input logic            ce2,
   input logic            op_valid,
   input logic [1:0]      cfg_mode,
   input logic            seq_done,
   input logic            seq_abort,
   input logic            pd_active,
   input logic [1:0]      pd_mode,
   input logic [ADDR_W:0] retain_words
);

   AST_FLAGS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
      !(seq_done && seq_abort)); // R9

   AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      seq_done |=> !seq_done); // R9

   AST_ABORT_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      seq_abort |=> !seq_abort); // R9

   AST_CFG_ONLY_ON_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      !seq_done |-> $stable(cfg_mode)); // R10

   AST_ABORT_FROM_OP: assert property (@(posedge clk) disable iff (!rst_n)
      seq_abort |-> $past(op_valid && ce2)); // R3

   AST_LOW_CE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && !ce2) |=> (!seq_done && !seq_abort)); // R7

   AST_PD_ENTRY_MODE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pd_active) |-> (pd_mode == $past(cfg_mode))); // R8

   AST_NO_RETAIN_AWAKE: assert property (@(posedge clk) disable iff (!rst_n)
      !pd_active |-> (retain_words == '0)); // R8

endmodule

bind pdcfg_seq_detect pdcfg_seq_detect_chk #(.ADDR_W(ADDR_W)) i_chk (
   .clk(clk), .rst_n(rst_n), .ce2(ce2), .op_valid(op_valid),
   .cfg_mode(cfg_mode), .seq_done(seq_done), .seq_abort(seq_abort),
   .pd_active(pd_active), .pd_mode(pd_mode), .retain_words(retain_words)
);

// File: tb/test_pdcfg_seq_detect.sv
`timescale 1ns/1ps
module test_pdcfg_seq_detect;
   localparam int AW = 21;
   localparam int DW = 16;
   localparam logic [AW-1:0] TOP = '1;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          ce2 = 1'b1;
   logic          op_valid = 1'b0;
   logic          op_write = 1'b0;
   logic [AW-1:0] op_addr = '0;
   logic [DW-1:0] op_data = '0;
   logic [1:0]    cfg_mode, pd_mode;
   logic          seq_done, seq_abort, pd_active;
   logic [AW:0]   retain_words;

   int n_chk = 0;
   int n_err = 0;

   // reference model state
   int         m_st = 0;
   logic [DW-1:0] m_ref = '0, m_cd = '0;
   logic [1:0] m_cfg = 2'd0, m_pdm = 2'd0;
   bit         m_pda = 1'b0;

   always #5 clk = ~clk;

   pdcfg_seq_detect i_pdcfg_seq_detect (
      .clk(clk), .rst_n(rst_n), .ce2(ce2), .op_valid(op_valid),
      .op_write(op_write), .op_addr(op_addr), .op_data(op_data),
      .cfg_mode(cfg_mode), .seq_done(seq_done), .seq_abort(seq_abort),
      .pd_active(pd_active), .pd_mode(pd_mode), .retain_words(retain_words)
   );

   task automatic chk(string tag, longint act, longint exp);
      n_chk++;
      if (act != exp) begin
         n_err++;
         $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   function automatic longint keep_of(logic [1:0] m, bit act);
      if (!act || m == 2'd0) return 0;
      return longint'(1) << (AW - 4 + int'(m));
   endfunction

   // expected reaction to one access (R2..R7)
   task automatic model(bit w, logic [AW-1:0] a, logic [DW-1:0] d,
                        output bit ed, output bit ea);
      bit top_rd, top_wr, brk;
      ed = 0; ea = 0; brk = 0;
      if (!ce2) return;
      top_rd = (a == TOP) && !w;
      top_wr = (a == TOP) && w;
      case (m_st)
         0: if (top_rd) begin m_ref = d; m_st = 1; end
         1, 2: if (top_wr && d == m_ref) m_st = m_st + 1; else brk = 1;
         3: if (top_wr) begin m_cd = d; m_st = 4; end else brk = 1;
         4: if (top_wr && d == m_cd) m_st = 5; else brk = 1;
         default: if (top_rd) begin ed = 1; m_cfg = m_cd[1:0]; m_st = 0; end
                  else brk = 1;
      endcase
      if (brk) begin
         ea = 1;
         if (top_rd) begin m_ref = d; m_st = 1; end else m_st = 0;
      end
   endtask

   task automatic do_op(bit w, logic [AW-1:0] a, logic [DW-1:0] d,
                        string tag, bit fall = 0);
      bit ed, ea;
      @(negedge clk);
      chk("R9 flags idle between accesses", {seq_done, seq_abort}, 0);
      if (fall) begin
         ce2 = 1'b0;
         m_st = 0;
      end
      op_valid = 1'b1; op_write = w; op_addr = a; op_data = d;
      model(w, a, d, ed, ea);
      @(negedge clk);
      op_valid = 1'b0;
      if (fall) begin
         if (!m_pda) m_pdm = m_cfg;
         m_pda = 1'b1;
      end
      chk({tag, " seq_done"}, seq_done, ed);
      chk({tag, " seq_abort"}, seq_abort, ea);
      chk({tag, " cfg_mode"}, cfg_mode, m_cfg);
   endtask

   task automatic set_ce2(bit v);
      @(negedge clk);
      ce2 = v;
      if (!v) m_st = 0;
      @(negedge clk);
      if (!v && !m_pda) m_pdm = m_cfg;
      m_pda = !v;
      chk("R8 pd_active", pd_active, m_pda);
      if (m_pda) chk("R8 pd_mode", pd_mode, m_pdm);
      chk("R8 retain_words", retain_words, keep_of(m_pdm, m_pda));
   endtask

   task automatic full_seq(logic [DW-1:0] rd, logic [DW-1:0] cw, string tag);
      do_op(0, TOP, rd, tag);
      do_op(1, TOP, rd, tag);
      do_op(1, TOP, rd, tag);
      do_op(1, TOP, cw, tag);
      do_op(1, TOP, cw, tag);
      do_op(0, TOP, $urandom, tag);
   endtask

   initial begin
      #(200000 * 10);
      n_err++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk + 1);
      $finish;
   end

   initial begin
      void'($urandom(32'd4711));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk("R1 cfg_mode", cfg_mode, 0);
      chk("R1 seq_done", seq_done, 0);
      chk("R1 seq_abort", seq_abort, 0);
      chk("R1 pd_active", pd_active, 0);
      chk("R1 retain_words", retain_words, 0);

      // R2 each mode committed, R8 region reported at power-down
      full_seq(16'hA5C3, 16'h1231, "R2 mode1");
      set_ce2(0); set_ce2(1);
      full_seq(16'h0F0F, 16'hBEE2, "R2 mode2");
      set_ce2(0); set_ce2(1);
      full_seq(16'h7777, 16'h0003, "R2 mode3");
      set_ce2(0); set_ce2(1);
      full_seq(16'h0000, 16'hFFFC, "R2 mode0");
      set_ce2(0); set_ce2(1);
      full_seq(16'h1357, 16'h0002, "R2 mode2 again");

      // R3 access 3 to another address, then wrong write-back data
      do_op(0, TOP, 16'h4444, "R3");
      do_op(1, TOP, 16'h4444, "R3");
      do_op(1, 21'h000005, 16'h4444, "R3 op3 other address");
      do_op(0, TOP, 16'h5555, "R3");
      do_op(1, TOP, 16'h5556, "R3 op2 wrong data");

      // R4 differing configuration words, and a write as access 6
      do_op(0, TOP, 16'h9999, "R4");
      do_op(1, TOP, 16'h9999, "R4");
      do_op(1, TOP, 16'h9999, "R4");
      do_op(1, TOP, 16'h0001, "R4");
      do_op(1, TOP, 16'h0003, "R4 op5 mismatch");
      full_seq(16'h2222, 16'h0001, "R4 setup");
      do_op(0, TOP, 16'h3333, "R4");
      do_op(1, TOP, 16'h3333, "R4");
      do_op(1, TOP, 16'h3333, "R4");
      do_op(1, TOP, 16'h0003, "R4");
      do_op(1, TOP, 16'h0003, "R4");
      do_op(1, TOP, 16'h0003, "R4 op6 is a write");

      // R5 cancelling top read restarts the sequence
      do_op(0, TOP, 16'h6666, "R5");
      do_op(1, TOP, 16'h6666, "R5");
      do_op(0, TOP, 16'h8888, "R5 restart read");
      do_op(1, TOP, 16'h8888, "R5");
      do_op(1, TOP, 16'h8888, "R5");
      do_op(1, TOP, 16'h0002, "R5");
      do_op(1, TOP, 16'h0002, "R5");
      do_op(0, TOP, 16'h0000, "R5 completes");

      // R6 noise while idle
      for (int i = 0; i < 8; i++)
         do_op(i[0], 21'(i * 977), 16'(i * 31), "R6 idle noise");

      // R7 accesses while ce2 low, and attempt dropped at power-down
      do_op(0, TOP, 16'hAAAA, "R7");
      do_op(1, TOP, 16'hAAAA, "R7");
      set_ce2(0);
      full_seq(16'h1111, 16'h0003, "R7 ignored while low");
      set_ce2(1);
      do_op(1, TOP, 16'hAAAA, "R7 attempt was dropped");

      // collision: access 6 on the same edge as power-down entry
      do_op(0, TOP, 16'hC0DE, "R8 collision");
      do_op(1, TOP, 16'hC0DE, "R8 collision");
      do_op(1, TOP, 16'hC0DE, "R8 collision");
      do_op(1, TOP, 16'h0003, "R8 collision");
      do_op(1, TOP, 16'h0003, "R8 collision");
      do_op(0, TOP, 16'h0000, "R7 op6 at ce2 fall", 1);
      chk("R8 collision pd_mode keeps old", pd_mode, m_pdm);
      chk("R8 collision retain", retain_words, keep_of(m_pdm, 1));
      set_ce2(1);

      // random sequences with one corrupted access
      for (int it = 0; it < 250; it++) begin
         logic [DW-1:0] rd, cw;
         int bad, kind;
         rd = 16'($urandom); cw = 16'($urandom);
         bad = ($urandom % 2) ? int'($urandom % 6) : -1;
         for (int k = 0; k < 6; k++) begin
            bit w; logic [AW-1:0] a; logic [DW-1:0] d;
            w = (k != 0 && k != 5);
            a = TOP;
            d = (k == 0 || k == 1 || k == 2) ? rd : cw;
            if (k == bad) begin
               kind = int'($urandom % 3);
               if (kind == 0) w = ~w;
               else if (kind == 1) a = 21'($urandom) & 21'h0FFFFF;
               else d = d ^ 16'(1 << ($urandom % 16));
            end
            do_op(w, a, d, "R2 random");
         end
         if ($urandom % 8 == 0) begin
            set_ce2(0);
            set_ce2(1);
         end
      end

      @(negedge clk);
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

endmodule